// File: doc/BRIEF.md
# Deferred Register Store Sequencer

This block holds a small bank of data registers that stand in for nonvolatile storage behind a two-wire serial slave, together with the timed write cycle that changes them. The bus front end passes it decoded store requests as they arrive within a transaction. A request either writes a host-supplied value into a register or copies the current wiper position into a register. The block holds the request pending and acts on it only when the transaction ends with a stop condition.

A store that is launched raises a busy flag for a fixed number of clock cycles. The target register changes in one step at the end of that period. While busy, the block tells the front end to withhold the acknowledge of its slave address, so a host can poll until the write has finished. An active-low write-protect input vetoes stores. A repeated start before the stop discards the pending request.

The block also serves register reads and drives the register-0 value that the wiper loads at power-up. A load of the wiper from a register is volatile and never reaches this block as a store.

Top module: `nv_store_seq`

## Requirements
- R1: Four 6-bit registers are selected by a 2-bit pointer. `rd_data` shows register `rd_sel` combinationally. Reset loads register k from bits [6k+5:6k] of `INIT_IMAGE`.
- R2: `recall_val` always equals register 0.
- R3: A cycle with `req_valid` high records a pending store to register `req_sel`. When `req_src` is 0 the data is `req_data`; when it is 1 the data is `wiper_val`. Both are sampled in that cycle. A later request in the same transaction replaces an earlier one. No register changes and `busy` stays low until a stop arrives.
- R4: A `bus_stop` cycle with a store pending and `wp_n` high raises `busy` at that clock edge. `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R5: The target register takes its new value at the edge where `busy` falls. Reads return the old value while `busy` is high.
- R6: `addr_ack_en` is low while `busy` is high and high otherwise.
- R7: While `busy` is high, `req_valid`, `bus_start` and `bus_stop` have no effect.
- R8: A stop cycle with `wp_n` low discards the pending store. `busy` is not raised, no register changes, and `addr_ack_en` stays high.
- R9: `bus_start` clears any pending store, so a repeated start before the stop discards it. A request in the same cycle as `bus_start` or `bus_stop` is dropped.
- R10: A stop with no store pending leaves `busy` low and the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_n | input | 1 | Write protect, low blocks stores |
| bus_start | input | 1 | One-cycle pulse on a start or repeated start condition |
| bus_stop | input | 1 | One-cycle pulse on a stop condition |
| req_valid | input | 1 | One-cycle pulse for a decoded store request |
| req_src | input | 1 | Store source: 0 host data, 1 wiper position |
| req_sel | input | 2 | Target register pointer |
| req_data | input | 6 | Host data for a register write |
| wiper_val | input | 6 | Current wiper position |
| rd_sel | input | 2 | Read pointer |
| rd_data | output | 6 | Contents of the register selected by rd_sel |
| recall_val | output | 6 | Register 0 contents, for power-up wiper recall |
| busy | output | 1 | Write cycle in progress |
| addr_ack_en | output | 1 | Slave address may be acknowledged |

## Verification
The hardest state to reach from the ports is a bus event that arrives in the middle of a write cycle. This covers a new request, a repeated start and a stray stop during busy, and it only counts if each is later shown to have left no pending store behind. Directed sequences launch a store and then inject all three during the busy window. The bench then waits for completion, issues a lone stop and checks that no second cycle starts. Seeded random transactions mix request counts, sources, write-protect states and restart-terminated transactions, and check the register image against a bench model after each one.

// File: rtl/nv_store_pkg.sv
package nv_store_pkg;

  typedef enum logic {
    SRC_HOST  = 1'b0,
    SRC_WIPER = 1'b1
  } store_src_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/nv_req_latch.sv
module nv_req_latch
  import nv_store_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              wp_n_i,
  input  logic              bus_start_i,
  input  logic              bus_stop_i,
  input  logic              req_valid_i,
  input  store_src_e        req_src_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [DATA_W-1:0] wiper_i,
  output logic              launch_o,
  output logic [SEL_W-1:0]  tgt_sel_o,
  output logic [DATA_W-1:0] tgt_data_o
);

  logic              pend_q, pend_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept;
  logic              take_req;

  assign accept   = !busy_i;
  assign take_req = accept && req_valid_i && !bus_start_i && !bus_stop_i;

  always_comb begin
    pend_d = pend_q;
    sel_d  = sel_q;
    data_d = data_q;
    if (accept) begin
      if (bus_start_i || bus_stop_i) begin
        pend_d = 1'b0;
      end else if (take_req) begin
        pend_d = 1'b1;
        sel_d  = req_sel_i;
        data_d = (req_src_i == SRC_WIPER) ? wiper_i : req_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (take_req) begin
        sel_q  <= sel_d;
        data_q <= data_d;
      end
    end
  end

  assign launch_o   = accept && bus_stop_i && pend_q && wp_n_i;
  assign tgt_sel_o  = sel_q;
  assign tgt_data_o = data_q;

  // R9
  start_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start_i && !busy_i) |=> !pend_q);

  // R7
  busy_holds_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> ($stable(sel_q) && $stable(data_q)));

endmodule

// File: rtl/nv_write_timer.sv
module nv_write_timer
  import nv_store_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 250000,
  localparam int unsigned CNT_W    = cnt_width(WR_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic busy_o,
  output logic commit_o
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CNT_LAST);
  assign cnt_en   = launch_i || busy_o;

  always_comb begin
    cnt_d = cnt_q;
    if (launch_i && !busy_o) begin
      cnt_d = CNT_LOAD;
    end else if (busy_o) begin
      cnt_d = cnt_q - CNT_LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> busy_o);

  // R5
  fall_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(commit_o));

endmodule

// File: rtl/nv_reg_bank.sv
module nv_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 6,
  parameter int SEL_W    = 2,
  parameter logic [NUM_REGS*DATA_W-1:0] INIT_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] recall_o
);

  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic wr_en;
    assign wr_en = commit_i && (wr_sel_i == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= INIT_IMAGE[g*DATA_W +: DATA_W];
      end else if (wr_en) begin
        mem_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_sel_i];
  assign recall_o  = mem_q[0];

  // R5
  only_commit_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(mem_q));

endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq
  import nv_store_pkg::*;
#(
  parameter int          NUM_REGS  = 4,
  parameter int          DATA_W    = 6,
  parameter int unsigned WR_CYCLES = 250000,
  parameter logic [NUM_REGS*DATA_W-1:0] INIT_IMAGE = '0,
  localparam int         SEL_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              req_valid,
  input  logic              req_src,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] wiper_val,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] recall_val,
  output logic              busy,
  output logic              addr_ack_en
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              launch;
  logic              commit;
  logic [SEL_W-1:0]  tgt_sel;
  logic [DATA_W-1:0] tgt_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  nv_req_latch #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_latch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .busy_i      (busy),
    .wp_n_i      (wp_n),
    .bus_start_i (bus_start),
    .bus_stop_i  (bus_stop),
    .req_valid_i (req_valid),
    .req_src_i   (store_src_e'(req_src)),
    .req_sel_i   (req_sel),
    .req_data_i  (req_data),
    .wiper_i     (wiper_val),
    .launch_o    (launch),
    .tgt_sel_o   (tgt_sel),
    .tgt_data_o  (tgt_data)
  );

  nv_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .launch_i (launch),
    .busy_o   (busy),
    .commit_o (commit)
  );

  nv_reg_bank #(
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W),
    .SEL_W      (SEL_W),
    .INIT_IMAGE (INIT_IMAGE)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .commit_i  (commit),
    .wr_sel_i  (tgt_sel),
    .wr_data_i (tgt_data),
    .rd_sel_i  (rd_sel),
    .rd_data_o (rd_data),
    .recall_o  (recall_val)
  );

  assign addr_ack_en = !busy;

  // R4
  rise_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> ($past(bus_stop) && $past(wp_n)));

  // R8
  protect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_stop && !wp_n && !busy) |=> !busy);

  // R2
  recall_matches_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sel == '0) |-> (recall_val == rd_data));

endmodule

// File: tb/nv_store_seq_tb.sv
module nv_store_seq_tb;

  localparam int N = 12;
  localparam logic [23:0] INIT = {6'd41, 6'd7, 6'd63, 6'd18};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_n = 1'b1;
  logic       bus_start = 1'b0, bus_stop = 1'b0, req_valid = 1'b0, req_src = 1'b0;
  logic [1:0] req_sel = '0, rd_sel = '0;
  logic [5:0] req_data = '0, wiper_val = '0;
  logic [5:0] rd_data, recall_val;
  logic       busy, addr_ack_en;

  int total = 0;
  int bad = 0;
  logic [5:0] exp_mem [4];
  bit         pend;
  logic [1:0] psel;
  logic [5:0] pdata;

  always #10 clk = ~clk;

  nv_store_seq #(.WR_CYCLES(N), .INIT_IMAGE(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .bus_start(bus_start),
    .bus_stop(bus_stop), .req_valid(req_valid), .req_src(req_src),
    .req_sel(req_sel), .req_data(req_data), .wiper_val(wiper_val),
    .rd_sel(rd_sel), .rd_data(rd_data), .recall_val(recall_val),
    .busy(busy), .addr_ack_en(addr_ack_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit st, input bit sp, input bit rv, input bit src,
                       input logic [1:0] sel, input logic [5:0] d, input logic [5:0] w);
    bus_start = st; bus_stop = sp; req_valid = rv; req_src = src;
    req_sel = sel; req_data = d; wiper_val = w;
    @(negedge clk);
    bus_start = 0; bus_stop = 0; req_valid = 0;
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k);
      #1;
      check({tag, " R1 read"}, rd_data, exp_mem[k]);
    end
    check({tag, " R2 recall"}, recall_val, exp_mem[0]);
    rd_sel = 0;
  endtask

  // called at the negedge after the stop edge; expects a launched cycle
  task automatic wait_store(input string tag);
    int cnt = 0;
    check({tag, " R6 ack low"}, addr_ack_en, 0);
    rd_sel = psel; #1;
    check({tag, " R5 old value"}, rd_data, exp_mem[psel]);
    while (busy && cnt < 4 * N) begin
      cnt++;
      @(negedge clk);
    end
    check({tag, " R4 busy length"}, cnt, N);
    check({tag, " R6 ack high"}, addr_ack_en, 1);
    exp_mem[psel] = pdata;
    pend = 0;
  endtask

  task automatic do_stop(input string tag);
    bit launch;
    launch = pend && wp_n;
    pulse(0, 1, 0, 0, 0, 0, 0);
    check({tag, " R4/R8/R10 busy after stop"}, busy, launch);
    if (launch) wait_store(tag);
    pend = 0;
    read_all(tag);
  endtask

  task automatic request(input bit src, input logic [1:0] sel, input logic [5:0] d,
                         input logic [5:0] w);
    pulse(0, 0, 1, src, sel, d, w);
    pend = 1; psel = sel; pdata = src ? w : d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2718));
    for (int k = 0; k < 4; k++) exp_mem[k] = INIT[k*6 +: 6];
    pend = 0; psel = 0; pdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    check("R4 reset busy", busy, 0);
    check("R6 reset ack", addr_ack_en, 1);
    read_all("reset");

    // R3: host write, latest request wins, no change before stop
    pulse(1, 0, 0, 0, 0, 0, 0); pend = 0;
    request(0, 2'd1, 6'd5, 6'd0);
    request(0, 2'd2, 6'd33, 6'd0);
    repeat (3) @(negedge clk);
    check("R3 no busy before stop", busy, 0);
    read_all("R3 pre-stop");
    do_stop("R3 host");

    // R3: wiper source
    pulse(1, 0, 0, 0, 0, 0, 0); pend = 0;
    request(1, 2'd0, 6'd9, 6'd50);
    do_stop("R3 wiper");

    // R7: bus events during busy are ignored
    pulse(1, 0, 0, 0, 0, 0, 0); pend = 0;
    request(0, 2'd3, 6'd11, 6'd0);
    pulse(0, 1, 0, 0, 0, 0, 0);
    check("R7 launched", busy, 1);
    pulse(0, 0, 1, 0, 2'd2, 6'd60, 6'd0);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 1, 0, 0, 0, 0, 0);
    check("R7 still busy", busy, 1);
    while (busy) @(negedge clk);
    exp_mem[3] = 6'd11; pend = 0;
    read_all("R7 after");
    pulse(0, 1, 0, 0, 0, 0, 0);
    check("R7 ignored request left no pending", busy, 0);
    read_all("R7 lone stop");

    // R8: write protect
    pulse(1, 0, 0, 0, 0, 0, 0); pend = 0;
    request(0, 2'd1, 6'd22, 6'd0);
    wp_n = 0;
    pulse(0, 1, 0, 0, 0, 0, 0);
    check("R8 no busy", busy, 0);
    check("R8 ack kept", addr_ack_en, 1);
    wp_n = 1; pend = 0;
    read_all("R8");
    pulse(0, 1, 0, 0, 0, 0, 0);
    check("R8 store discarded", busy, 0);

    // R9: repeated start discards, same-cycle request dropped
    pulse(1, 0, 0, 0, 0, 0, 0); pend = 0;
    request(0, 2'd2, 6'd1, 6'd0);
    pulse(1, 0, 1, 0, 2'd2, 6'd2, 6'd0); pend = 0;
    pulse(0, 1, 0, 0, 0, 0, 0);
    check("R9 restart discards", busy, 0);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 1, 1, 0, 2'd0, 6'd3, 6'd0);
    check("R9 request at stop dropped", busy, 0);
    read_all("R9");

    // R10: stop with nothing pending
    pulse(1, 0, 0, 0, 0, 0, 0); pend = 0;
    do_stop("R10");

    // random transactions
    for (int t = 0; t < 40; t++) begin
      int nreq, mode;
      pulse(1, 0, 0, 0, 0, 0, 0); pend = 0;
      nreq = $urandom % 3;
      for (int r = 0; r < nreq; r++) begin
        request(1'($urandom), 2'($urandom), 6'($urandom), 6'($urandom));
        repeat ($urandom % 3) @(negedge clk);
      end
      mode = $urandom % 4;
      if (mode == 2) wp_n = 0;
      if (mode == 3) begin
        pulse(1, 0, 0, 0, 0, 0, 0); pend = 0;
      end
      do_stop("rand R3/R4/R5/R8/R9");
      wp_n = 1;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule